// File: doc/BRIEF.md
# USB Root-Hub Port Status and Control Register

This block holds the 32-bit status and control word of one USB root-hub port. Software reads the word at any time through `rd_data` and updates it with single-cycle writes (`wr_en` with `wr_data`). Within that one word, each field follows its own access rule. Some bits are read-only mirrors of port inputs. Some are ordinary read/write. The port reset bit is write-1-to-set. The enable bit and the seven change flags are write-1-to-clear. The link-state field is written only when a strobe bit is set in the same write. The reserved bits always read zero.

Hardware events also update the word. A toggle on the connect or over-current input raises the matching change flag. A port reset ends by itself after a programmable number of cycles, and its completion enables the port and raises the reset-change flag. A disconnect while the port is enabled turns the port off and raises the enable-change flag. A write that keeps only the read-only and read/write bits of a value just read back leaves the port exactly as it was. Software relies on this rule to modify one field without side effects.

Top module: `port_ctl_reg`

## Requirements
- R1: Bits 0 (connect), 3 (over-current), 13:10 (speed) and 30 (device removable) show `conn_i`, `ovc_i`, `speed_i` and `removable_i` as sampled at the previous clock edge. Writes have no effect on them.
- R2: Bit 9 (port power), bits 15:14 (indicator) and bits 27:25 (wake enables) take the written value on every write, whether that value is 0 or 1.
- R3: Bits 8:5 (link state) take `wr_data[8:5]` only in a write that has bit 16 set. Bit 16 always reads 0.
- R4: Writing 1 to bit 4 (port reset) while no reset is running sets the bit, and it then reads 1 for exactly RST_CYC cycles before clearing. Writing 0 to bit 4 has no effect. Writing 1 while a reset is running does not restart it.
- R5: In the cycle where a reset completes, the port becomes enabled (bit 1 = 1) and the reset-change flag (bit 21) is set.
- R6: Writing 1 to bit 1 clears the enable bit, and writing 0 has no effect. A falling edge on `conn_i` while the port is enabled also clears the enable bit and sets the enable-change flag (bit 18), unless a reset completes in that same cycle.
- R7: The change flags in bits 23:17 are cleared by writing 1 to them, and writing 0 has no effect. If a set event occurs in the same cycle as the clearing write, the set wins.
- R8: The change flags are set by these events: bit 17 on any toggle of `conn_i`; bit 19 on `warm_done_i`; bit 20 on any toggle of `ovc_i`; bit 22 on a strobed write that changes the link-state value; bit 23 on `l1_evt_i`.
- R9: Bits 2, 24, 28, 29 and 31 always read 0.
- R10: Writing back `rd_data` masked to its read-only and plain read/write bits (bits 0, 3, 9:5, 15:10, 27:25, 30) leaves every stored field unchanged.
- R11: `port_active_o` is 1 exactly when bit 1 is 1 and the link-state code is below 3. Code 0 means active, 3 means suspended and 15 means resume.
- R12: After reset, every stored field is zero and no port reset is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data word |
| rd_data | output | 32 | Current register word |
| conn_i | input | 1 | Device connected |
| ovc_i | input | 1 | Over-current present |
| speed_i | input | 4 | Port speed code |
| removable_i | input | 1 | Device non-removable indication |
| warm_done_i | input | 1 | Warm reset finished pulse |
| l1_evt_i | input | 1 | L1 state change pulse |
| port_active_o | output | 1 | Port enabled and link below suspended |

## Verification
The assertions assume that all port inputs are synchronous to `clk` and that `RST_CYC` is at least 1. They also assume that the event pulses may land in any cycle, including the same cycle as a clearing write. The stimulus changes inputs only on the falling clock edge. It mixes random writes, occasional connect and over-current toggles and random event pulses. Clearing writes to the change flags are kept rare, so that flags stay set for long enough to be observed. Directed sequences cover the strobe gating, a full reset, a disconnect while enabled, a set/clear collision and a neutral write-back.

// File: rtl/psc_pkg.sv
// Field positions and shared codes for the port status/control word.
// Assumes a 32-bit word. Software decodes these positions, so they are fixed.
package psc_pkg;
    localparam int WORD_W    = 32;
    localparam int B_CONN    = 0;
    localparam int B_EN      = 1;
    localparam int B_OC      = 3;
    localparam int B_RST     = 4;
    localparam int B_PLS_LO  = 5;
    localparam int B_PLS_HI  = 8;
    localparam int B_PWR     = 9;
    localparam int B_SPD_LO  = 10;
    localparam int B_SPD_HI  = 13;
    localparam int B_IND_LO  = 14;
    localparam int B_IND_HI  = 15;
    localparam int B_STB     = 16;
    localparam int B_CHG_LO  = 17;
    localparam int B_CHG_HI  = 23;
    localparam int B_WAKE_LO = 25;
    localparam int B_WAKE_HI = 27;
    localparam int B_REM     = 30;
    localparam int NUM_CHG   = B_CHG_HI - B_CHG_LO + 1;
    localparam int PLS_W     = B_PLS_HI - B_PLS_LO + 1;

    // Change-flag index, in the order of the flags in the word.
    typedef enum logic [2:0] {
        CHG_CONN = 3'd0, CHG_EN = 3'd1, CHG_WARM = 3'd2, CHG_OC = 3'd3,
        CHG_RST  = 3'd4, CHG_LINK = 3'd5, CHG_L1 = 3'd6
    } chg_e;

    localparam logic [PLS_W-1:0] LS_U0     = 4'd0;
    localparam logic [PLS_W-1:0] LS_U3     = 4'd3;
    localparam logic [PLS_W-1:0] LS_RESUME = 4'd15;
endpackage

// File: rtl/psc_chg_flag.sv
// One sticky change flag. A set event raises it, and a write of 1 clears it.
// Assumes set_i and clr_i are synchronous single-cycle qualifiers. Set wins over clear.
module psc_chg_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Hold the flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
endmodule

// File: rtl/psc_rst_timer.sv
// Self-clearing port reset timer. Once started, busy_o stays high for RST_CYC cycles.
// done_o is high in the last of those cycles. A start while busy is ignored.
module psc_rst_timer #(
    parameter int RST_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYC - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Load the counter on a start, count down while busy, and drop busy at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD;
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && (cnt_q == '0);

    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);
    p_w0_noeffect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);
    p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/port_ctl_reg.sv
// Per-port status and control register for a USB root-hub port.
// Mixes read-only, read/write, write-1-to-set, write-1-to-clear, strobed and reserved fields.
// Assumes port inputs are synchronous to clk. Reads are combinational from the stored state.
module port_ctl_reg
    import psc_pkg::*;
#(
    parameter int RST_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              conn_i,
    input  logic              ovc_i,
    input  logic [3:0]        speed_i,
    input  logic              removable_i,
    input  logic              warm_done_i,
    input  logic              l1_evt_i,
    output logic              port_active_o
);
    localparam int SPD_W  = B_SPD_HI - B_SPD_LO + 1;
    localparam int IND_W  = B_IND_HI - B_IND_LO + 1;
    localparam int WAKE_W = B_WAKE_HI - B_WAKE_LO + 1;

    logic              conn_q, ovc_q, rem_q, en_q, pwr_q;
    logic [SPD_W-1:0]  spd_q;
    logic [PLS_W-1:0]  pls_q;
    logic [IND_W-1:0]  ind_q;
    logic [WAKE_W-1:0] wake_q;
    logic              rst_busy, rst_done, conn_fall, stb_wr;
    logic [NUM_CHG-1:0] chg_set, chg_clr, chg_q;
    logic              unused_wr_bits;

    assign conn_fall = conn_q && !conn_i;
    assign stb_wr    = wr_en && wr_data[B_STB];

    // Sample the read-only status inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q <= 1'b0;
            ovc_q  <= 1'b0;
            spd_q  <= '0;
            rem_q  <= 1'b0;
        end else begin
            conn_q <= conn_i;
            ovc_q  <= ovc_i;
            spd_q  <= speed_i;
            rem_q  <= removable_i;
        end
    end

    // Plain read/write fields: the written value replaces the old one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q  <= 1'b0;
            ind_q  <= '0;
            wake_q <= '0;
        end else if (wr_en) begin
            pwr_q  <= wr_data[B_PWR];
            ind_q  <= wr_data[B_IND_HI:B_IND_LO];
            wake_q <= wr_data[B_WAKE_HI:B_WAKE_LO];
        end
    end

    // Link state is taken only when the strobe bit is set in the same write.
    always_ff @(posedge clk) begin
        if (!rst_n)      pls_q <= LS_U0;
        else if (stb_wr) pls_q <= wr_data[B_PLS_HI:B_PLS_LO];
    end

    // Enable: set by reset completion; cleared by a write of 1 or by a disconnect.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  en_q <= 1'b0;
        else if (rst_done)                           en_q <= 1'b1;
        else if ((wr_en && wr_data[B_EN]) || conn_fall) en_q <= 1'b0;
    end

    psc_rst_timer #(.RST_CYC(RST_CYC)) u_rst_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wr_en && wr_data[B_RST]),
        .busy_o  (rst_busy),
        .done_o  (rst_done)
    );

    // Set events of the change flags, one per flag index.
    always_comb begin
        chg_set                = '0;
        chg_set[int'(CHG_CONN)] = conn_i ^ conn_q;
        chg_set[int'(CHG_EN)]   = conn_fall && en_q && !rst_done;
        chg_set[int'(CHG_WARM)] = warm_done_i;
        chg_set[int'(CHG_OC)]   = ovc_i ^ ovc_q;
        chg_set[int'(CHG_RST)]  = rst_done;
        chg_set[int'(CHG_LINK)] = stb_wr && (wr_data[B_PLS_HI:B_PLS_LO] != pls_q);
        chg_set[int'(CHG_L1)]   = l1_evt_i;
    end

    assign chg_clr = wr_en ? wr_data[B_CHG_HI:B_CHG_LO] : '0;

    for (genvar g = 0; g < NUM_CHG; g++) begin : g_chg
        psc_chg_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (chg_set[g]),
            .clr_i  (chg_clr[g]),
            .flag_o (chg_q[g])
        );
    end

    // Assemble the read word; reserved bits and the strobe read zero.
    always_comb begin
        rd_data                       = '0;
        rd_data[B_CONN]               = conn_q;
        rd_data[B_EN]                 = en_q;
        rd_data[B_OC]                 = ovc_q;
        rd_data[B_RST]                = rst_busy;
        rd_data[B_PLS_HI:B_PLS_LO]    = pls_q;
        rd_data[B_PWR]                = pwr_q;
        rd_data[B_SPD_HI:B_SPD_LO]    = spd_q;
        rd_data[B_IND_HI:B_IND_LO]    = ind_q;
        rd_data[B_CHG_HI:B_CHG_LO]    = chg_q;
        rd_data[B_WAKE_HI:B_WAKE_LO]  = wake_q;
        rd_data[B_REM]                = rem_q;
    end

    assign port_active_o = en_q && (pls_q < LS_U3);

    assign unused_wr_bits = ^{wr_data[B_CONN], wr_data[2], wr_data[B_OC],
                              wr_data[B_SPD_HI:B_SPD_LO], wr_data[24],
                              wr_data[31:28]};

    p_ro_conn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_data[B_CONN] == $past(conn_i)));
    p_strobe_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_wr |=> $stable(rd_data[B_PLS_HI:B_PLS_LO]));
    p_done_enables_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |=> (rd_data[B_EN] && rd_data[B_CHG_LO + int'(CHG_RST)]));
    p_en_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_EN] && !rst_done) |=> !rd_data[B_EN]);
endmodule

// File: tb/tb_port_ctl_reg.sv
// Self-checking bench: directed cases followed by seeded random traffic against a field model.
module tb_port_ctl_reg;
    localparam int CLK_PERIOD = 10;
    localparam int RST_CYC    = 6;
    localparam logic [31:0] KEEP_MASK = 32'h4E00_FFE9; // bits 0,3,9:5,15:10,27:25,30

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        conn_i = 1'b0, ovc_i = 1'b0, removable_i = 1'b0;
    logic [3:0]  speed_i = '0;
    logic        warm_done_i = 1'b0, l1_evt_i = 1'b0;
    logic        port_active_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Model state
    logic       m_conn, m_en, m_oc, m_rst, m_pwr, m_rem;
    int         m_cnt;
    logic [3:0] m_pls, m_spd;
    logic [1:0] m_ind;
    logic [2:0] m_wake;
    logic [6:0] m_flg;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_ctl_reg #(.RST_CYC(RST_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .conn_i(conn_i), .ovc_i(ovc_i), .speed_i(speed_i), .removable_i(removable_i),
        .warm_done_i(warm_done_i), .l1_evt_i(l1_evt_i), .port_active_o(port_active_o)
    );

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[0] = m_conn; w[1] = m_en; w[3] = m_oc; w[4] = m_rst; w[8:5] = m_pls;
        w[9] = m_pwr; w[13:10] = m_spd; w[15:14] = m_ind; w[23:17] = m_flg;
        w[27:25] = m_wake; w[30] = m_rem;
        return w;
    endfunction

    function automatic string tag_of(input logic [31:0] d);
        for (int i = 0; i < 32; i++) begin
            if (d[i]) begin
                if (i == 0 || i == 3 || (i >= 10 && i <= 13) || i == 30) return "R1";
                if (i == 9 || i == 14 || i == 15 || (i >= 25 && i <= 27)) return "R2";
                if ((i >= 5 && i <= 8) || i == 16) return "R3";
                if (i == 4) return "R4";
                if (i == 1) return "R6";
                if (i >= 17 && i <= 23) return "R8";
                return "R9";
            end
        end
        return "R11";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_conn = 0; m_en = 0; m_oc = 0; m_rst = 0; m_pwr = 0; m_rem = 0; m_cnt = 0;
        m_pls = 0; m_spd = 0; m_ind = 0; m_wake = 0; m_flg = 0;
    endtask

    // Apply the register rules for one clock edge with the current inputs.
    task automatic model_step(input logic we, input logic [31:0] wd);
        logic done, cfall, plc;
        logic [6:0] ev, clr;
        done  = m_rst && (m_cnt == 0);
        cfall = m_conn && !conn_i;
        plc   = we && wd[16] && (wd[8:5] != m_pls);
        ev    = {l1_evt_i, plc, done, (m_oc ^ ovc_i), warm_done_i,
                 (cfall && m_en && !done), (m_conn ^ conn_i)};
        clr   = we ? wd[23:17] : 7'd0;
        if (m_rst) begin
            if (done) m_rst = 0; else m_cnt--;
        end else if (we && wd[4]) begin
            m_rst = 1; m_cnt = RST_CYC - 1;
        end
        if (done) m_en = 1;
        else if ((we && wd[1]) || cfall) m_en = 0;
        if (we && wd[16]) m_pls = wd[8:5];
        if (we) begin m_pwr = wd[9]; m_ind = wd[15:14]; m_wake = wd[27:25]; end
        m_flg  = (m_flg & ~clr) | ev;
        m_conn = conn_i; m_oc = ovc_i; m_spd = speed_i; m_rem = removable_i;
    endtask

    // One clock: drive at the falling edge, step the model, compare at the next falling edge.
    task automatic tick(input logic we, input logic [31:0] wd, input logic wdn, input logic l1);
        logic [31:0] e;
        wr_en = we; wr_data = wd; warm_done_i = wdn; l1_evt_i = l1;
        model_step(we, wd);
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; warm_done_i = 0; l1_evt_i = 0;
        e = exp_word();
        chk(rd_data == e, tag_of(rd_data ^ e), rd_data, e);
        chk(port_active_o == (m_en && m_pls < 3), "R11", {31'd0, port_active_o},
            {31'd0, (m_en && m_pls < 3)});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 32'd0, 1'b0, 1'b0);
    endtask

    initial begin
        logic [31:0] w;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(rd_data == 32'd0, "R12", rd_data, 32'd0);

        // R2: plain read/write fields set, then cleared
        tick(1'b1, 32'h0E00_C200, 1'b0, 1'b0);
        chk(rd_data[9] && rd_data[15:14] == 2'b11 && rd_data[27:25] == 3'b111, "R2", rd_data, 32'h0E00_C200);
        tick(1'b1, 32'h0000_0000, 1'b0, 1'b0);
        chk(rd_data == 32'd0, "R2", rd_data, 32'd0);

        // R1: writes to read-only bits ignored; R9 reserved bits read zero
        tick(1'b1, 32'hF100_3C0D, 1'b0, 1'b0);
        chk((rd_data & 32'hF100_3C0D) == 32'd0, "R1", rd_data, 32'd0);
        // R8: connect toggle sets bit 17 and shows on bit 0
        conn_i = 1'b1; speed_i = 4'd3;
        tick(1'b0, 32'd0, 1'b0, 1'b0);
        chk(rd_data[0] && rd_data[17] && rd_data[13:10] == 4'd3, "R8", rd_data, 32'h0002_0C01);

        // R3: link state without strobe is ignored; with strobe it is taken
        tick(1'b1, 32'h0000_0060, 1'b0, 1'b0);
        chk(rd_data[8:5] == 4'd0, "R3", rd_data, 32'd0);
        tick(1'b1, 32'h0001_0060, 1'b0, 1'b0);
        chk(rd_data[8:5] == 4'd3 && !rd_data[16] && rd_data[22], "R3", rd_data, 32'h0042_0061);
        tick(1'b1, 32'h0001_0000, 1'b0, 1'b0);

        // R4: writing 0 to reset has no effect, writing 1 starts it
        tick(1'b1, 32'h0000_0000, 1'b0, 1'b0);
        chk(!rd_data[4], "R4", rd_data, 32'd0);
        tick(1'b1, 32'h0000_0010, 1'b0, 1'b0);
        chk(rd_data[4], "R4", rd_data, 32'h10);
        idle(RST_CYC - 1);
        chk(rd_data[4], "R4", rd_data, 32'h10);
        idle(1);
        // R5: completion enables the port and flags reset change
        chk(!rd_data[4] && rd_data[1] && rd_data[21], "R5", rd_data, 32'h0020_0002);
        chk(port_active_o, "R11", {31'd0, port_active_o}, 32'd1);

        // R10: neutral write-back leaves the state unchanged
        w = rd_data;
        tick(1'b1, w & KEEP_MASK, 1'b0, 1'b0);
        chk(rd_data == w, "R10", rd_data, w);

        // R7: writing 0 to flags has no effect, writing 1 clears, set wins over clear
        tick(1'b1, 32'h0000_0000, 1'b0, 1'b0);
        chk(rd_data[21], "R7", rd_data, 32'h0020_0000);
        tick(1'b1, 32'h00FE_0000, 1'b0, 1'b1);
        chk(rd_data[23:17] == 7'b1000000, "R7", rd_data, 32'h0080_0000);

        // R11: suspended link makes the port inactive
        tick(1'b1, 32'h0001_0060, 1'b0, 1'b0);
        chk(!port_active_o, "R11", {31'd0, port_active_o}, 32'd0);
        tick(1'b1, 32'h0001_0000, 1'b0, 1'b0);

        // R6: disconnect while enabled clears enable and sets bit 18
        conn_i = 1'b0;
        tick(1'b0, 32'd0, 1'b0, 1'b0);
        chk(!rd_data[1] && rd_data[18], "R6", rd_data, 32'h0004_0000);

        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            logic we;
            logic [31:0] wd;
            we = ($urandom % 2) == 0;
            wd = $urandom;
            if (($urandom % 8) != 0) begin wd[23:17] = '0; wd[1] = 1'b0; end
            if (($urandom % 4) != 0) wd[4] = 1'b0;
            if (($urandom % 8) == 0) conn_i = ~conn_i;
            if (($urandom % 16) == 0) ovc_i = ~ovc_i;
            if (($urandom % 32) == 0) speed_i = 4'($urandom);
            if (($urandom % 32) == 0) removable_i = ~removable_i;
            tick(we, wd, ($urandom % 16) == 0, ($urandom % 16) == 0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule